// File: doc/BRIEF.md
# Configurable Asynchronous Serial Line Engine

This block runs one asynchronous serial line in both directions. A single 16-bit line word, written through a simple write port, sets the whole character format and the speeds of both directions. It sets the number of data bits, whether a parity bit is present and its sense, and one or two stop bits on transmit. Separate 4-bit speed codes pick the transmit and receive rates. A half-duplex flag lets the line share one wire with its own transmitter. The line word resets to zero, so the receiver starts out disabled.

Bit timing comes from a vector of tick enables, one per speed code, that the surrounding logic provides at 16 times the bit rate. Each direction takes the tick that its speed code selects and counts 16 of them per bit. The transmitter accepts one byte on a valid/ready handshake and shifts it out least significant bit first. The receiver confirms the start bit at mid-bit, samples each later bit in its middle, checks parity and the stop bit, and then gives a one-cycle pulse with the byte and two flags. A low stop bit is reported as a framing error, and that same flag is the break indication.

Transmit states are TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP:
- TX_IDLE goes to TX_START when a byte is accepted.
- TX_START goes to TX_DATA after one bit time.
- TX_DATA goes to TX_PARITY after the last data bit if parity is on, and to TX_STOP otherwise.
- TX_PARITY goes to TX_STOP after one bit time.
- TX_STOP returns to TX_IDLE after one bit time, or after two when two stop bits are selected.

Receive states are RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP:
- RX_IDLE goes to RX_START when the synchronised line is low.
- RX_START goes to RX_DATA if the line is still low at the 8th tick. Otherwise it returns to RX_IDLE.
- RX_DATA goes to RX_PARITY or RX_STOP after the last data sample, depending on whether parity is on.
- RX_PARITY goes to RX_STOP after its sample.
- RX_STOP returns to RX_IDLE after its sample and raises the output pulse.
- From any receive state, a disabled receiver forces RX_IDLE.

Top module: `serial_line_engine`

## Requirements
- R1: Reset values: the line word is zero, txd is high, tx_ready is high and rx_valid is low. While the line word is zero, no character is received.
- R2: Line word bits [1:0] give the data length: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8. Data bits travel least significant bit first in both directions. Received bits above the length read as zero.
- R3: Line word bit 2 set gives two high stop bits on transmit, and clear gives one. tx_ready rises only after the last stop bit.
- R4: Line word bit 4 enables a parity bit, sent right after the data bits. Bit 5 set selects odd parity, so the data bits plus the parity bit hold an odd number of ones. Bit 5 clear selects even parity.
- R5: Line word bits [13:10] are the transmit speed code and bits [9:6] the receive speed code. Each code picks bit `code` of tick16_en, and one bit lasts 16 of those ticks.
- R6: While the receive speed code is zero, the receiver is held idle: no rx_valid pulse, and any reception in progress is dropped.
- R7: When line word bit 14 (half duplex) is set, the receiver ignores rxd and stays idle while the transmitter is busy.
- R8: rx_parity_err is set when parity is enabled and the received parity bit does not match the selected sense of the received data bits. It is clear when parity is off.
- R9: rx_break is set when the stop bit is sampled low. A line held low for a whole character gives data 0 with rx_break set.
- R10: A start bit counts only if rxd is still low at the 8th tick after the falling edge. A shorter low pulse produces no character, and the next proper character is still received.
- R11: A byte is taken when tx_valid and tx_ready are both high, and tx_ready is low in the cycle that follows. rx_valid is a one-cycle pulse, and rx_data and the flags hold until the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Line word write strobe |
| cfg_wdata | input | 16 | Line word write data |
| tick16_en | input | 16 | 16x bit-rate tick enable, one per speed code |
| tx_valid | input | 1 | Transmit byte valid |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter can accept a byte |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line |
| rx_valid | output | 1 | One-cycle pulse: a received character is available |
| rx_data | output | 8 | Received byte, right-aligned |
| rx_parity_err | output | 1 | Parity mismatch on the received character |
| rx_break | output | 1 | Stop bit low (framing error, break) |

## Verification
The checks assume that the line word stays the same while a character is in flight in either direction. The upper-bits-zero property reads the length from the live line word when the pulse appears. The checks also assume that a tick enable is a single-cycle pulse. The stimulus writes the line word only while both directions are idle, and it drives each tick as one cycle out of every code+1 cycles. It drives rxd edges only at bit boundaries that it computes from that same tick period, except for a deliberate short low pulse used to test start-bit rejection.

// File: rtl/sce_pkg.sv
package sce_pkg;

    localparam int LINE_W = 16;
    localparam int SPD_W  = 4;
    localparam int BYTE_W = 8;

    // Field positions inside the line word
    localparam int F_LEN_LO  = 0;
    localparam int F_TWOSTOP = 2;
    localparam int F_PAREN   = 4;
    localparam int F_PARODD  = 5;
    localparam int F_RXSPD   = 6;
    localparam int F_TXSPD   = 10;
    localparam int F_HALFDUP = 14;

    typedef struct packed {
        logic [3:0]       nbits;
        logic             two_stop;
        logic             par_en;
        logic             par_odd;
        logic [SPD_W-1:0] rx_spd;
        logic [SPD_W-1:0] tx_spd;
        logic             half_dup;
    } line_fmt_t;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP
    } rx_state_e;

    function automatic logic [BYTE_W-1:0] len_mask(input logic [3:0] n);
        logic [BYTE_W-1:0] m;
        for (int i = 0; i < BYTE_W; i++) begin
            m[i] = (4'(i) < n);
        end
        return m;
    endfunction

    function automatic logic par_bit(input logic [BYTE_W-1:0] d,
                                     input logic [3:0] n,
                                     input logic odd);
        return (^(d & len_mask(n))) ^ odd;
    endfunction

endpackage

// File: rtl/sce_cfg.sv
module sce_cfg
    import sce_pkg::*;
#(
    parameter logic [LINE_W-1:0] RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [LINE_W-1:0] wdata,
    output logic [LINE_W-1:0] word_q,
    output line_fmt_t         fmt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= RESET_WORD;
        end else if (we) begin
            word_q <= wdata;
        end
    end

    always_comb begin
        fmt.nbits    = 4'd5 + {2'b00, word_q[F_LEN_LO +: 2]};
        fmt.two_stop = word_q[F_TWOSTOP];
        fmt.par_en   = word_q[F_PAREN];
        fmt.par_odd  = word_q[F_PARODD];
        fmt.rx_spd   = word_q[F_RXSPD +: SPD_W];
        fmt.tx_spd   = word_q[F_TXSPD +: SPD_W];
        fmt.half_dup = word_q[F_HALFDUP];
    end

endmodule

// File: rtl/sce_tx.sv
module sce_tx
    import sce_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  line_fmt_t         fmt,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd,
    output logic              busy
);

    localparam int            CW   = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    tx_state_e         st, st_nx;
    logic [CW-1:0]     cnt;
    logic [3:0]        bitn;
    logic [3:0]        nb_q;
    logic [BYTE_W-1:0] sh;
    logic              par_q;
    logic              pen_q;
    logic              extra_stop;
    logic              bit_end;

    assign bit_end = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TX_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE:   if (in_valid) st_nx = TX_START;
            TX_START:  if (bit_end) st_nx = TX_DATA;
            TX_DATA:   if (bit_end && (bitn == nb_q - 4'd1))
                           st_nx = pen_q ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) st_nx = TX_STOP;
            TX_STOP:   if (bit_end && !extra_stop) st_nx = TX_IDLE;
            default:   st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bitn       <= '0;
            nb_q       <= 4'd8;
            sh         <= '0;
            par_q      <= 1'b0;
            pen_q      <= 1'b0;
            extra_stop <= 1'b0;
        end else if (st == TX_IDLE) begin
            cnt  <= '0;
            bitn <= '0;
            if (in_valid) begin
                sh         <= in_data & len_mask(fmt.nbits);
                par_q      <= par_bit(in_data, fmt.nbits, fmt.par_odd);
                nb_q       <= fmt.nbits;
                pen_q      <= fmt.par_en;
                extra_stop <= fmt.two_stop;
            end
        end else if (tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
            if (bit_end && st == TX_DATA) begin
                sh   <= sh >> 1;
                bitn <= bitn + 4'd1;
            end
            if (bit_end && st == TX_STOP) begin
                extra_stop <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (st)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = sh[0];
            TX_PARITY: txd = par_q;
            TX_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
        in_ready = (st == TX_IDLE);
        busy     = (st != TX_IDLE);
    end

endmodule

// File: rtl/sce_rx.sv
module sce_rx
    import sce_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  line_fmt_t         fmt,
    input  logic              enable,
    input  logic              rxd,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_perr,
    output logic              out_ferr
);

    localparam int            CW   = $clog2(OVS);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

    rx_state_e         st, st_nx;
    logic [SYNC-1:0]   sync_q;
    logic              rx_s;
    logic [CW-1:0]     cnt;
    logic [3:0]        bitn;
    logic [BYTE_W-1:0] sh;
    logic              perr_q;
    logic              mid_hit;
    logic              samp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], rxd};
        end
    end

    assign rx_s    = sync_q[SYNC-1];
    assign mid_hit = tick && (cnt == MID);
    assign samp    = tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RX_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        if (!enable) begin
            st_nx = RX_IDLE;
        end else begin
            unique case (st)
                RX_IDLE:   if (!rx_s) st_nx = RX_START;
                RX_START:  if (mid_hit) st_nx = rx_s ? RX_IDLE : RX_DATA;
                RX_DATA:   if (samp && (bitn == fmt.nbits - 4'd1))
                               st_nx = fmt.par_en ? RX_PARITY : RX_STOP;
                RX_PARITY: if (samp) st_nx = RX_STOP;
                RX_STOP:   if (samp) st_nx = RX_IDLE;
                default:   st_nx = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            bitn      <= '0;
            sh        <= '0;
            perr_q    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_perr  <= 1'b0;
            out_ferr  <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            unique case (st)
                RX_IDLE: begin
                    cnt <= '0;
                end
                RX_START: begin
                    if (tick) cnt <= mid_hit ? '0 : cnt + 1'b1;
                    if (mid_hit) begin
                        bitn   <= '0;
                        sh     <= '0;
                        perr_q <= 1'b0;
                    end
                end
                RX_DATA: begin
                    if (tick) cnt <= samp ? '0 : cnt + 1'b1;
                    if (samp) begin
                        sh[bitn[2:0]] <= rx_s;
                        bitn          <= bitn + 4'd1;
                    end
                end
                RX_PARITY: begin
                    if (tick) cnt <= samp ? '0 : cnt + 1'b1;
                    if (samp) perr_q <= (rx_s != par_bit(sh, fmt.nbits, fmt.par_odd));
                end
                RX_STOP: begin
                    if (tick) cnt <= samp ? '0 : cnt + 1'b1;
                    if (samp && enable) begin
                        out_valid <= 1'b1;
                        out_data  <= sh;
                        out_perr  <= perr_q;
                        out_ferr  <= !rx_s;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/serial_line_engine.sv
module serial_line_engine
    import sce_pkg::*;
#(
    parameter int OVS  = 16,
    parameter int SYNC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [LINE_W-1:0]   cfg_wdata,
    input  logic [(1<<SPD_W)-1:0] tick16_en,
    input  logic                tx_valid,
    input  logic [BYTE_W-1:0]   tx_data,
    output logic                tx_ready,
    output logic                txd,
    input  logic                rxd,
    output logic                rx_valid,
    output logic [BYTE_W-1:0]   rx_data,
    output logic                rx_parity_err,
    output logic                rx_break
);

    logic [LINE_W-1:0] cfg_q;
    line_fmt_t         fmt;
    logic              tx_tick;
    logic              rx_tick;
    logic              tx_busy;
    logic              rx_enable;

    sce_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .word_q (cfg_q),
        .fmt    (fmt)
    );

    assign tx_tick   = tick16_en[fmt.tx_spd];
    assign rx_tick   = tick16_en[fmt.rx_spd];
    assign rx_enable = (fmt.rx_spd != '0) && !(fmt.half_dup && tx_busy);

    sce_tx #(.OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tx_tick),
        .fmt      (fmt),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .txd      (txd),
        .busy     (tx_busy)
    );

    sce_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rx_tick),
        .fmt       (fmt),
        .enable    (rx_enable),
        .rxd       (rxd),
        .out_valid (rx_valid),
        .out_data  (rx_data),
        .out_perr  (rx_parity_err),
        .out_ferr  (rx_break)
    );

endmodule

// File: rtl/serial_line_engine_chk.sv
module serial_line_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cfg_q,
    input logic        tx_busy,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        txd,
    input logic        rx_valid,
    input logic [7:0]  rx_data
);

    logic [7:0] width_mask;
    assign width_mask = 8'hFF >> (2'd3 - cfg_q[1:0]);

    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    assert_accept_drops_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_rx_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_rx_off_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[9:6] == 4'd0) |=> !rx_valid);

    assert_half_duplex_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[14] && tx_busy) |=> !rx_valid);

    assert_upper_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data & ~width_mask) == 8'h00));

endmodule

bind serial_line_engine serial_line_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_q    (cfg_q),
    .tx_busy  (tx_busy),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .txd      (txd),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
);

// File: tb/sim_serial_line_engine.sv
module sim_serial_line_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    // {line word, byte}
    localparam logic [23:0] VEC [0:NVEC-1] = '{
        {16'h0443, 8'hA5},   // 8 bits, no parity, 1 stop
        {16'h0452, 8'h53},   // 7 bits, even parity
        {16'h0472, 8'h53},   // 7 bits, odd parity
        {16'h0475, 8'h2D},   // 6 bits, odd parity, 2 stop
        {16'h0440, 8'hFF},   // 5 bits, no parity
        {16'h0897, 8'h3C},   // 8 bits even, 2 stop, speed 2
        {16'h0473, 8'h00}    // 8 bits odd parity
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] tick16_en = '0;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        tx_ready, txd, rxd, rx_valid, rx_parity_err, rx_break;
    logic [7:0]  rx_data;
    logic        rxd_drv = 1'b1;
    logic        loop_en = 1'b0;

    int checks = 0;
    int fails = 0;
    int rx_events = 0;
    logic [7:0] ev_data = '0;
    logic ev_perr = 1'b0;
    logic ev_ferr = 1'b0;
    bit done = 1'b0;

    assign rxd = loop_en ? txd : rxd_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_line_engine u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_wdata     (cfg_wdata),
        .tick16_en     (tick16_en),
        .tx_valid      (tx_valid),
        .tx_data       (tx_data),
        .tx_ready      (tx_ready),
        .txd           (txd),
        .rxd           (rxd),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_parity_err (rx_parity_err),
        .rx_break      (rx_break)
    );

    // Tick for speed code c: one cycle out of every c+1
    initial begin
        int g = 0;
        forever begin
            @(negedge clk);
            g++;
            for (int i = 0; i < 16; i++) tick16_en[i] = ((g % (i + 1)) == 0);
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid === 1'b1) begin
                rx_events++;
                ev_data = rx_data;
                ev_perr = rx_parity_err;
                ev_ferr = rx_break;
            end
        end
    end

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [15:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [7:0] bmask(input logic [15:0] w);
        return 8'hFF >> (3 - w[1:0]);
    endfunction

    function automatic logic exp_par(input logic [15:0] w, input logic [7:0] d);
        return (^(d & bmask(w))) ^ w[5];
    endfunction

    // Drive one character on rxd at the receive speed of w
    task automatic drive_frame(input logic [15:0] w, input logic [7:0] d,
                               input logic flip_par, input logic stop_v);
        int p = int'(w[9:6]) + 1;
        int nb = 5 + int'(w[1:0]);
        rxd_drv = 1'b0;
        wait_cyc(16 * p);
        for (int i = 0; i < nb; i++) begin
            rxd_drv = d[i];
            wait_cyc(16 * p);
        end
        if (w[4]) begin
            rxd_drv = exp_par(w, d) ^ flip_par;
            wait_cyc(16 * p);
        end
        rxd_drv = stop_v;
        wait_cyc(16 * p);
        rxd_drv = 1'b1;
        wait_cyc(16 * p);
    endtask

    // Send a byte and check every bit of the frame on txd
    task automatic tx_and_check(input logic [15:0] w, input logic [7:0] d);
        int p = int'(w[13:10]) + 1;
        int nb = 5 + int'(w[1:0]);
        int k = 0;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R11 ready low after accept", 32'(tx_ready), 32'd0);
        while (txd !== 1'b0 && k < 64) begin
            @(negedge clk);
            k++;
        end
        wait_cyc(8 * p);
        chk("R5 start bit", 32'(txd), 32'd0);
        for (int i = 0; i < nb; i++) begin
            wait_cyc(16 * p);
            chk("R2 data bit", 32'(txd), 32'(d[i]));
        end
        if (w[4]) begin
            wait_cyc(16 * p);
            chk("R4 parity bit", 32'(txd), 32'(exp_par(w, d)));
        end
        wait_cyc(16 * p);
        chk("R3 stop bit high", 32'(txd), 32'd1);
        chk("R3 busy in stop", 32'(tx_ready), 32'd0);
        wait_cyc(16 * p);
        chk("R3 stop count", 32'(tx_ready), 32'(!w[2]));
        chk("R3 line high", 32'(txd), 32'd1);
        wait_cyc(16 * p);
    endtask

    initial begin
        int ev0;
        wait_cyc(5);
        chk("R1 txd in reset", 32'(txd), 32'd1);
        chk("R1 rx_valid in reset", 32'(rx_valid), 32'd0);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 tx_ready after reset", 32'(tx_ready), 32'd1);

        // Receiver disabled by the reset line word
        ev0 = rx_events;
        drive_frame(16'h0443, 8'h42, 1'b0, 1'b1);
        chk("R1 no receive at reset word", 32'(rx_events), 32'(ev0));

        // Table walk: loopback, frame on txd and received character
        loop_en = 1'b1;
        for (int v = 0; v < NVEC; v++) begin
            logic [15:0] w = VEC[v][23:8];
            logic [7:0]  d = VEC[v][7:0];
            set_cfg(w);
            ev0 = rx_events;
            tx_and_check(w, d);
            chk("R11 one character", 32'(rx_events), 32'(ev0 + 1));
            chk("R2 rx data", 32'(ev_data), 32'(d & bmask(w)));
            chk("R8 no parity error", 32'(ev_perr), 32'd0);
            chk("R9 no break", 32'(ev_ferr), 32'd0);
            chk("R11 data held", 32'(rx_data), 32'(d & bmask(w)));
        end

        // Half duplex: own transmission not received
        set_cfg(16'h4443);
        ev0 = rx_events;
        tx_and_check(16'h4443, 8'h96);
        chk("R7 half duplex ignores line", 32'(rx_events), 32'(ev0));
        loop_en = 1'b0;

        // Parity error on an 8-bit even parity character
        set_cfg(16'h0453);
        ev0 = rx_events;
        drive_frame(16'h0453, 8'h81, 1'b1, 1'b1);
        chk("R8 character seen", 32'(rx_events), 32'(ev0 + 1));
        chk("R8 parity error set", 32'(ev_perr), 32'd1);
        chk("R8 data kept", 32'(ev_data), 32'h81);
        chk("R9 stop good", 32'(ev_ferr), 32'd0);

        // Break: line low for 9.75 bit times
        set_cfg(16'h0443);
        ev0 = rx_events;
        rxd_drv = 1'b0;
        wait_cyc(156 * 2);
        rxd_drv = 1'b1;
        wait_cyc(3 * 32);
        chk("R9 break one character", 32'(rx_events), 32'(ev0 + 1));
        chk("R9 break flag", 32'(ev_ferr), 32'd1);
        chk("R9 break data zero", 32'(ev_data), 32'h00);

        // Zero receive speed: nothing received
        set_cfg(16'h0403);
        ev0 = rx_events;
        drive_frame(16'h0443, 8'h3A, 1'b0, 1'b1);
        chk("R6 zero speed no receive", 32'(rx_events), 32'(ev0));

        // Short low pulse rejected, then a proper character
        set_cfg(16'h0443);
        ev0 = rx_events;
        rxd_drv = 1'b0;
        wait_cyc(4 * 2);
        rxd_drv = 1'b1;
        wait_cyc(2 * 32);
        chk("R10 glitch rejected", 32'(rx_events), 32'(ev0));
        drive_frame(16'h0443, 8'h5A, 1'b0, 1'b1);
        chk("R10 next character received", 32'(rx_events), 32'(ev0 + 1));
        chk("R10 next character data", 32'(ev_data), 32'h5A);

        // Receive at speed 3 with 6 bits and odd parity
        set_cfg(16'h0CF1);
        ev0 = rx_events;
        drive_frame(16'h0CF1, 8'h2B, 1'b0, 1'b1);
        chk("R5 receive speed 3", 32'(rx_events), 32'(ev0 + 1));
        chk("R5 receive speed 3 data", 32'(ev_data), 32'h2B);
        chk("R4 odd parity accepted", 32'(ev_perr), 32'd0);

        summary();
    end

endmodule